// File: doc/BRIEF.md
# Pattern-Slot Lane Crossbar

This block moves lanes of a wide vector to new lane positions in one registered step. Each of the N output lanes can take its value from any of the N input lanes, and every lane is 16 bits wide. The routing is not supplied as a mux select on every cycle. Instead, each crosspoint (input i, output j) keeps a small local store with one enable bit per pattern slot. There are six slots by default.

A slot is filled ahead of time through a write port. Each write names a slot, an output column and a source input. The write enables that one crosspoint in the column and clears every other crosspoint in the same column for that slot. A write with the enable flag low clears the whole column for that slot. A column can therefore have at most one source per slot, but one input may feed any number of outputs.

At run time the issuing instruction supplies a 3-bit pattern index along with the data. A small decoder turns the index into a one-hot slot choice and sends it to every crosspoint, so the whole stored permutation is applied at once. The network is sized for 128 lanes; the default is 8 lanes so that verification stays small.

Top module: `swz_xbar`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and low after any edge where `in_valid` was low. Output lane j (bits 16j+15:16j of `out_data`) then equals input lane src, where src is the source stored for column j in the slot named by `pat_sel`.
- R2: An output lane whose column has no enabled crosspoint in the selected slot reads as zero.
- R3: One input lane may be routed to several output lanes in the same slot. Examples are a pairwise broadcast (output j takes input j/2) and a rotation within groups of four.
- R4: A write to a column replaces any earlier source for that column in that slot. A write with `cfg_en` low leaves the column with no source, so that lane reads zero.
- R5: A write takes effect from the next edge on. A vector sampled at the same edge as the write still uses the slot's previous contents, and a vector at the following edge uses the new contents.
- R6: A `pat_sel` value of 6 or 7 (or any value not below the slot count) drives every output lane to zero.
- R7: A write whose `cfg_slot` is 6 or 7 changes no slot.
- R8: While `in_valid` is low, `out_data` holds its last value.
- R9: After reset, `out_valid` and `out_data` are zero and every slot is empty, so any selected slot yields all-zero lanes.
- R10: Slots are independent. Vectors issued back to back with a different `pat_sel` on each cycle each get their own slot's routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Pattern slot to write |
| cfg_out | input | log2(LANES) | Output column to write |
| cfg_src | input | log2(LANES) | Source input lane for that column |
| cfg_en | input | 1 | 1 enables the named source, 0 clears the column |
| in_valid | input | 1 | Input vector qualifier |
| pat_sel | input | 3 | Pattern slot applied to this vector |
| in_data | input | LANES*16 | Input lanes, lane k at bits 16k+15:16k |
| out_valid | output | 1 | Registered output qualifier |
| out_data | output | LANES*16 | Registered permuted lanes |

## Verification
The assertions take for granted that `rst` is applied before any vector and that `in_valid` and `pat_sel` are settled at each sampling edge. The stimulus changes inputs only on the falling clock edge. It also deliberately includes illegal slot indices on both the write port and the select port, since the block must handle these values rather than assume they never occur. A model in the bench tracks the per-slot column sources. Random writes, random selects and random idle cycles are mixed with directed broadcast, rotation, overwrite, clear and same-edge write-and-use cases.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int SLOT_W  = 3;
  localparam int LANE_DW = 16;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/swz_slot_dec.sv
module swz_slot_dec #(
  parameter int SLOTS = 6
) (
  input  logic                      wr_req,
  input  logic [swz_pkg::SLOT_W-1:0] wr_slot,
  input  logic [swz_pkg::SLOT_W-1:0] rd_slot,
  output logic [SLOTS-1:0]          wr_oh,
  output logic [SLOTS-1:0]          act_oh
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign wr_oh[s]  = wr_req && (wr_slot == swz_pkg::SLOT_W'(s));
    assign act_oh[s] = (rd_slot == swz_pkg::SLOT_W'(s));
  end
endmodule

// File: rtl/swz_cell.sv
module swz_cell #(
  parameter int SLOTS = 6,
  parameter int IW    = 3,
  parameter int ROW   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             col_hit,
  input  logic [SLOTS-1:0] wr_oh,
  input  logic [IW-1:0]    src,
  input  logic             en,
  input  logic [SLOTS-1:0] act_oh,
  output logic             xp_on
);
  logic [SLOTS-1:0] store_q;
  logic             mine;

  assign mine = en && (src == IW'(ROW));

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (col_hit) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wr_oh[s]) store_q[s] <= mine;
      end
    end
  end

  assign xp_on = |(store_q & act_oh);
endmodule

// File: rtl/swz_col_mux.sv
module swz_col_mux #(
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input  logic [LANES-1:0]    xp,
  input  logic [LANES*DW-1:0] din,
  output logic [DW-1:0]       dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < LANES; i++) begin
      dout = dout | (din[i*DW +: DW] & {DW{xp[i]}});
    end
  end
endmodule

// File: rtl/swz_xbar.sv
module swz_xbar #(
  parameter int LANES = 8,
  parameter int DW    = swz_pkg::LANE_DW,
  parameter int SLOTS = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [swz_pkg::SLOT_W-1:0]    cfg_slot,
  input  logic [swz_pkg::idx_w(LANES)-1:0] cfg_out,
  input  logic [swz_pkg::idx_w(LANES)-1:0] cfg_src,
  input  logic                          cfg_en,
  input  logic                          in_valid,
  input  logic [swz_pkg::SLOT_W-1:0]    pat_sel,
  input  logic [LANES*DW-1:0]           in_data,
  output logic                          out_valid,
  output logic [LANES*DW-1:0]           out_data
);
  localparam int IW = swz_pkg::idx_w(LANES);
  localparam int VW = LANES * DW;

  logic [SLOTS-1:0]       wr_oh;
  logic [SLOTS-1:0]       act_oh;
  logic [LANES*LANES-1:0] xp_on_flat;
  logic [VW-1:0]          routed;
  logic                   out_valid_q;
  logic [VW-1:0]          out_data_q;

  swz_slot_dec #(.SLOTS(SLOTS)) u_dec (
    .wr_req (cfg_we),
    .wr_slot(cfg_slot),
    .rd_slot(pat_sel),
    .wr_oh  (wr_oh),
    .act_oh (act_oh)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_col
    logic col_hit;
    assign col_hit = (cfg_out == IW'(j));

    for (genvar i = 0; i < LANES; i++) begin : g_row
      swz_cell #(.SLOTS(SLOTS), .IW(IW), .ROW(i)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .col_hit(col_hit),
        .wr_oh  (wr_oh),
        .src    (cfg_src),
        .en     (cfg_en),
        .act_oh (act_oh),
        .xp_on  (xp_on_flat[j*LANES + i])
      );
    end

    swz_col_mux #(.LANES(LANES), .DW(DW)) u_mux (
      .xp  (xp_on_flat[j*LANES +: LANES]),
      .din (in_data),
      .dout(routed[j*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= in_valid;
      if (in_valid) out_data_q <= routed;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/swz_xbar_chk.sv
module swz_xbar_chk #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int SLOTS = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [swz_pkg::SLOT_W-1:0] pat_sel,
  input logic                       out_valid,
  input logic [LANES*DW-1:0]        out_data,
  input logic [LANES*LANES-1:0]     xp_on_flat
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (int'(pat_sel) >= SLOTS)) |=> (out_data == '0));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  for (genvar j = 0; j < LANES; j++) begin : g_colchk
    p_one_src_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(xp_on_flat[j*LANES +: LANES]));
  end
endmodule

bind swz_xbar swz_xbar_chk #(.LANES(LANES), .DW(DW), .SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .pat_sel   (pat_sel),
  .out_valid (out_valid),
  .out_data  (out_data),
  .xp_on_flat(xp_on_flat)
);

// File: tb/swz_xbar_tb.sv
`timescale 1ns/1ps
module swz_xbar_tb;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int SLOTS = 6;
  localparam int IW    = swz_pkg::idx_w(LANES);
  localparam int VW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_slot = '0;
  logic [IW-1:0] cfg_out = '0;
  logic [IW-1:0] cfg_src = '0;
  logic          cfg_en = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    pat_sel = '0;
  logic [VW-1:0] in_data = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int mdl [SLOTS][LANES];
  logic [VW-1:0] prev_out = '0;

  always #2.5 clk = ~clk;

  swz_xbar #(.LANES(LANES), .DW(DW), .SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_out(cfg_out), .cfg_src(cfg_src), .cfg_en(cfg_en),
    .in_valid(in_valid), .pat_sel(pat_sel), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [VW-1:0] exp_out(input int sel, input logic [VW-1:0] d);
    logic [VW-1:0] r = '0;
    if (sel < SLOTS) begin
      for (int j = 0; j < LANES; j++) begin
        if (mdl[sel][j] >= 0) r[j*DW +: DW] = d[mdl[sel][j]*DW +: DW];
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic step(input bit we, input int slot, input int o, input int src,
                      input bit en, input bit v, input int sel,
                      input logic [VW-1:0] d, input string tag);
    logic [VW-1:0] e;
    @(negedge clk);
    cfg_we = we; cfg_slot = 3'(slot); cfg_out = IW'(o); cfg_src = IW'(src); cfg_en = en;
    in_valid = v; pat_sel = 3'(sel); in_data = d;
    e = v ? exp_out(sel, d) : prev_out;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== v || out_data !== e) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, out_valid, out_data, v, e);
    end
    prev_out = e;
    if (we && slot < SLOTS) begin
      for (int i = 0; i < LANES; i++) ;
      mdl[slot][o] = en ? src : -1;
    end
  endtask

  task automatic wr(input int slot, input int o, input int src, input bit en, input string tag);
    step(1'b1, slot, o, src, en, 1'b0, 0, '0, tag);
  endtask

  task automatic use_slot(input int sel, input string tag);
    step(1'b0, 0, 0, 0, 1'b0, 1'b1, sel, rnd_vec(), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < SLOTS; s++)
      for (int j = 0; j < LANES; j++) mdl[s][j] = -1;

    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R9: valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
    end
    for (int s = 0; s < SLOTS; s++) use_slot(s, "R9 empty slot");

    // Slot 0 identity, 1 pairwise broadcast, 2 rotate in fours, 3 reverse,
    // 4 even columns only from lane 0, 5 only column 0.
    for (int j = 0; j < LANES; j++) begin
      wr(0, j, j, 1'b1, "R8 idle during write");
      wr(1, j, j / 2, 1'b1, "R8 idle during write");
      wr(2, j, (j & ~3) | ((j + 1) & 3), 1'b1, "R8 idle during write");
      wr(3, j, LANES - 1 - j, 1'b1, "R8 idle during write");
      if (j % 2 == 0) wr(4, j, 0, 1'b1, "R8 idle during write");
    end
    wr(5, 0, 3, 1'b1, "R8 idle during write");

    use_slot(0, "R1 identity");
    use_slot(1, "R3 broadcast pairs");
    use_slot(2, "R3 rotate fours");
    use_slot(3, "R1 reverse");
    use_slot(4, "R2 unrouted columns zero");
    use_slot(5, "R2 single column");

    wr(3, 1, 6, 1'b1, "R4 overwrite");
    wr(3, 2, 0, 1'b0, "R4 clear");
    use_slot(3, "R4 overwrite and clear");

    // Same-edge write and use, then next-cycle use
    step(1'b1, 2, 0, 5, 1'b1, 1'b1, 2, rnd_vec(), "R5 same edge old route");
    use_slot(2, "R5 next edge new route");

    use_slot(6, "R6 select 6 zero");
    use_slot(7, "R6 select 7 zero");

    wr(6, 0, 7, 1'b1, "R7 illegal slot write");
    wr(7, 3, 1, 1'b0, "R7 illegal slot write");
    for (int s = 0; s < SLOTS; s++) use_slot(s, "R7 slots unchanged");

    step(1'b0, 0, 0, 0, 1'b0, 1'b0, 0, rnd_vec(), "R8 hold");
    step(1'b0, 0, 0, 0, 1'b0, 1'b0, 3, rnd_vec(), "R8 hold");

    for (int k = 0; k < 400; k++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 2)
        step(1'b1, int'($urandom_range(0, 7)), int'($urandom_range(0, LANES - 1)),
             int'($urandom_range(0, LANES - 1)), 1'($urandom_range(0, 3) != 0),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), rnd_vec(),
             "R5 random write with traffic");
      else if (r < 3)
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, int'($urandom_range(0, 7)), rnd_vec(), "R8 random idle");
      else
        use_slot(int'($urandom_range(0, 7)), "R10 back to back random");
    end

    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    finish_run();
  end
endmodule